// File: doc/BRIEF.md
# Bidirectional FIFO Loopback Controller

This block sits on the fabric side of a host link. It holds two first-in first-out queues. Each queue stores up to 256 words of 32 bits. The inbound queue takes words from the host. The outbound queue returns words to the host.

Between the two queues sit two small controllers and one holding register:

- The receive controller waits until the inbound queue holds data. It then pops exactly one word, waits out the two-cycle read latency, and latches the word. It then raises a ready flag.
- The send controller waits until the outbound queue has room. It then pushes the latched word and drops the ready flag.

Each queue has a status window that the host can read. Offset 0 gives the fill level. Offset 1 gives the full and empty bits. The block applies no backpressure. A write into a full queue, or a read from an empty one, is simply dropped.

When the host keeps writing without draining, the outbound queue fills and the loop stalls with one word held in the register. The inbound queue then keeps taking words until it is also full.

Top module: `fifo_loopback_ctrl`

## Requirements
- R1: After reset, both queues report level 0 with the empty bit set and the full bit clear. `loop_ready` is low and `host_rd_valid` is low.
- R2: A status window returns the fill level, zero-extended to 32 bits, when its select is 0. When its select is 1 it returns a flags word with full at bit 0, empty at bit 1, and all other bits 0.
- R3: A host write to the inbound queue stores the word and raises its level by one when the queue is not full. A write while the queue is full is ignored and the level stays at 256.
- R4: A host read pulse of one cycle pops the oldest outbound word. `host_rd_valid` and the word appear in the second cycle after the pulse. A read while the queue is empty is ignored: no valid strobe, and the level does not change.
- R5: When the inbound queue is not empty and ready is low, the receive controller drives its read enable for exactly one cycle. It then latches the returned word and sets ready.
- R6: While ready is high, the receive controller never reads the inbound queue, so the latched word is not overwritten.
- R7: When ready is high and the outbound queue is not full, the send controller pushes the latched word, and ready is low in the next cycle.
- R8: A word written into an empty, idle loop reaches the outbound queue as follows. Ready is high after the third clock edge that follows the write edge. The outbound level becomes 1 on the fourth edge.
- R9: If the host does not drain, the outbound queue fills to 256, ready stays high, and the inbound queue keeps filling to 256. Draining afterwards returns every accepted word in write order.
- R10: Fill levels stay within 0 to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host push into the inbound queue |
| host_wr_data | input | 32 | Word to push |
| host_rd_en | input | 1 | Host pop pulse from the outbound queue |
| host_rd_data | output | 32 | Popped word, valid with host_rd_valid |
| host_rd_valid | output | 1 | High in the second cycle after an accepted pop |
| in_st_sel | input | 1 | Inbound status window offset (0 level, 1 flags) |
| in_st_word | output | 32 | Inbound status window data |
| out_st_sel | input | 1 | Outbound status window offset (0 level, 1 flags) |
| out_st_word | output | 32 | Outbound status window data |
| loop_ready | output | 1 | Holding register contains an unsent word |

## Verification
Some rules are checked on every cycle by assertions:

- the receive read enable is a single-cycle pulse and is gated off while ready is high or the queue is empty;
- the send push happens only with ready high and space available, and clears ready;
- levels stay bounded;
- dropped writes and reads leave the level unchanged;
- an accepted host pop yields a valid strobe two cycles later.

Other behaviour only the directed scenarios can show:

- the exact four-edge transit latency;
- the status encodings;
- the stalled state, with both queues full and one word held;
- the in-order return of all 513 accepted words, with the excess write absent.

// File: rtl/lb_pkg.sv
// Shared definitions for the loopback controller: status bit
// positions, receive controller states and the status word builder.
package lb_pkg;
    localparam int ST_FULL_BIT  = 0;
    localparam int ST_EMPTY_BIT = 1;

    typedef enum logic {RX_IDLE, RX_WAIT} rx_state_e;

    // Build a 32-bit status window word from offset select and queue state.
    function automatic logic [31:0] status_word(input logic sel,
                                                input logic [31:0] lvl,
                                                input logic full,
                                                input logic empty);
        logic [31:0] w;
        w = '0;
        if (sel) begin
            w[ST_FULL_BIT]  = full;
            w[ST_EMPTY_BIT] = empty;
        end else begin
            w = lvl;
        end
        return w;
    endfunction
endpackage

// File: rtl/lb_fifo.sv
// Synchronous queue with a two-stage read pipeline.
// A pop accepted at one edge presents its word one edge later, so the
// word is valid in the second cycle after the enable. Writes when full
// and reads when empty are dropped. Assumes DEPTH is a power of two.
module lb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    output logic [DW-1:0]                rd_data,
    output logic                         rd_valid,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push, pop;
    logic [DW-1:0] q1;
    logic          v1;

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Pointer and level bookkeeping for accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Two-stage read pipeline giving the documented read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1       <= '0;
            v1       <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (pop) q1 <= mem[rptr];
            v1       <= pop;
            rd_data  <= q1;
            rd_valid <= v1;
        end
    end
endmodule

// File: rtl/lb_rx_ctl.sv
// Receive controller: pops one inbound word when data is present and the
// holding register is free, latches it when the read returns, and sets
// ready. Ready is cleared only by the send controller.
module lb_rx_ctl #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_valid,
    input  logic          clr_ready,
    output logic          rd_en,
    output logic [DW-1:0] hold_data,
    output logic          ready
);
    import lb_pkg::*;

    rx_state_e state;

    // Single-cycle read pulse: only issued from idle.
    assign rd_en = (state == RX_IDLE) && !fifo_empty && !ready;

    // State, holding register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            hold_data <= '0;
            ready     <= 1'b0;
        end else begin
            case (state)
                RX_IDLE: if (rd_en) state <= RX_WAIT;
                RX_WAIT: if (fifo_valid) begin
                    hold_data <= fifo_data;
                    ready     <= 1'b1;
                    state     <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
            if (clr_ready) ready <= 1'b0;
        end
    end
endmodule

// File: rtl/lb_tx_ctl.sv
// Send controller: pushes the held word into the outbound queue whenever
// ready is set and there is room, and requests ready to clear.
module lb_tx_ctl #(
    parameter int DW = 32
) (
    input  logic          ready,
    input  logic [DW-1:0] hold_data,
    input  logic          fifo_full,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          clr_ready
);
    // Push decision is purely combinational on ready and space.
    always_comb begin
        wr_en     = ready && !fifo_full;
        wr_data   = hold_data;
        clr_ready = wr_en;
    end
endmodule

// File: rtl/fifo_loopback_ctrl.sv
// Top: inbound queue -> receive controller -> holding register -> send
// controller -> outbound queue, plus a two-word status window per queue.
// Assumes the host never relies on backpressure.
module fifo_loopback_ctrl #(
    parameter int DW    = 32,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_rd_en,
    output logic [DW-1:0] host_rd_data,
    output logic          host_rd_valid,
    input  logic          in_st_sel,
    output logic [31:0]   in_st_word,
    input  logic          out_st_sel,
    output logic [31:0]   out_st_word,
    output logic          loop_ready
);
    import lb_pkg::*;
    localparam int LW = $clog2(DEPTH) + 1;

    logic [LW-1:0] in_level, out_level;
    logic          in_full, in_empty, out_full, out_empty;
    logic          in_rd_en, in_rd_valid, out_wr_en, clr_ready;
    logic [DW-1:0] in_rd_data, hold_data, out_wr_data;

    lb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr_en), .wr_data(host_wr_data),
        .rd_en(in_rd_en), .rd_data(in_rd_data), .rd_valid(in_rd_valid),
        .level(in_level), .full(in_full), .empty(in_empty)
    );

    lb_rx_ctl #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(in_empty), .fifo_data(in_rd_data), .fifo_valid(in_rd_valid),
        .clr_ready(clr_ready), .rd_en(in_rd_en),
        .hold_data(hold_data), .ready(loop_ready)
    );

    lb_tx_ctl #(.DW(DW)) u_tx (
        .ready(loop_ready), .hold_data(hold_data), .fifo_full(out_full),
        .wr_en(out_wr_en), .wr_data(out_wr_data), .clr_ready(clr_ready)
    );

    lb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(out_wr_en), .wr_data(out_wr_data),
        .rd_en(host_rd_en), .rd_data(host_rd_data), .rd_valid(host_rd_valid),
        .level(out_level), .full(out_full), .empty(out_empty)
    );

    // Status windows: offset 0 level, offset 1 flags.
    always_comb begin
        in_st_word  = status_word(in_st_sel,  32'(in_level),  in_full,  in_empty);
        out_st_word = status_word(out_st_sel, 32'(out_level), out_full, out_empty);
    end
endmodule

// File: rtl/lb_loop_chk.sv
// Protocol checker for the loopback controller, bound to the top.
module lb_loop_chk #(
    parameter int DEPTH = 256,
    parameter int LW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_rd_en,
    input logic          out_wr_en,
    input logic          loop_ready,
    input logic          in_empty,
    input logic          in_full,
    input logic          out_empty,
    input logic          out_full,
    input logic [LW-1:0] in_level,
    input logic [LW-1:0] out_level,
    input logic          host_wr_en,
    input logic          host_rd_en,
    input logic          host_rd_valid
);
    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |=> !in_rd_en);
    // R6
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> (!loop_ready && !in_empty));
    // R7
    send_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (loop_ready && !out_full));
    // R7
    send_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |=> !loop_ready);
    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_level <= LW'(DEPTH)) && (out_level <= LW'(DEPTH)));
    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && in_full && !in_rd_en) |=> $stable(in_level));
    // R4
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && !out_empty) |-> ##2 host_rd_valid);
    // R4
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && out_empty && !out_wr_en) |=> $stable(out_level));
endmodule

bind fifo_loopback_ctrl lb_loop_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_rd_en(in_rd_en), .out_wr_en(out_wr_en), .loop_ready(loop_ready),
    .in_empty(in_empty), .in_full(in_full),
    .out_empty(out_empty), .out_full(out_full),
    .in_level(in_level), .out_level(out_level),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_rd_valid(host_rd_valid)
);

// File: tb/sim_fifo_loopback_ctrl.sv
// Directed bench for the loopback controller.
module sim_fifo_loopback_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        host_rd_valid;
    logic        in_st_sel = 1'b0;
    logic [31:0] in_st_word;
    logic        out_st_sel = 1'b0;
    logic [31:0] out_st_word;
    logic        loop_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fifo_loopback_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .host_rd_valid(host_rd_valid),
        .in_st_sel(in_st_sel), .in_st_word(in_st_word),
        .out_st_sel(out_st_sel), .out_st_word(out_st_word),
        .loop_ready(loop_ready)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'(i) * 32'h9E37_79B1 + 32'h0000_1234;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_in(input logic sel, output logic [31:0] w);
        in_st_sel = sel; #1; w = in_st_word;
    endtask

    task automatic rd_out(input logic sel, output logic [31:0] w);
        out_st_sel = sel; #1; w = out_st_word;
    endtask

    task automatic host_write(input logic [31:0] d);
        @(negedge clk); host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] d, output logic v);
        @(negedge clk); host_rd_en = 1'b1;
        @(negedge clk); host_rd_en = 1'b0;
        @(negedge clk); d = host_rd_data; v = host_rd_valid;
    endtask

    // R1, R2: state right after reset.
    task automatic t_reset_state();
        logic [31:0] w;
        rd_in(1'b0, w);  check("R1 in level", w, 32'd0);
        rd_in(1'b1, w);  check("R2 in flags empty", w, 32'h2);
        rd_out(1'b0, w); check("R1 out level", w, 32'd0);
        rd_out(1'b1, w); check("R2 out flags empty", w, 32'h2);
        check("R1 ready low", 32'(loop_ready), 32'd0);
        check("R1 valid low", 32'(host_rd_valid), 32'd0);
    endtask

    // R4: reading an empty outbound queue is ignored.
    task automatic t_empty_read();
        logic [31:0] d, w; logic v;
        host_read(d, v);
        check("R4 empty read no valid", 32'(v), 32'd0);
        rd_out(1'b0, w); check("R4 empty read level", w, 32'd0);
    endtask

    // R5, R7, R8: single word transit latency and return.
    task automatic t_latency();
        logic [31:0] d, w; logic v;
        host_write(32'hCAFE_0001);
        rd_in(1'b0, w); check("R3 in level after write", w, 32'd1);
        @(negedge clk); @(negedge clk);
        check("R5 ready low before capture", 32'(loop_ready), 32'd0);
        @(negedge clk);
        check("R8 ready after third edge", 32'(loop_ready), 32'd1);
        rd_out(1'b0, w); check("R8 out level before push", w, 32'd0);
        rd_in(1'b0, w);  check("R5 in popped once", w, 32'd0);
        @(negedge clk);
        rd_out(1'b0, w); check("R8 out level after fourth edge", w, 32'd1);
        check("R7 ready cleared", 32'(loop_ready), 32'd0);
        host_read(d, v);
        check("R4 read valid", 32'(v), 32'd1);
        check("R4 read data", d, 32'hCAFE_0001);
        rd_out(1'b1, w); check("R2 out flags empty after read", w, 32'h2);
    endtask

    // R9, R3, R10: stall with both queues full, excess write dropped.
    task automatic t_stall_fill();
        logic [31:0] w;
        for (int i = 0; i < 513; i++) begin
            for (int k = 0; k < 1000; k++) begin
                rd_in(1'b1, w);
                if (w[0] == 1'b0) break;
                @(negedge clk);
            end
            host_write(pat(i));
        end
        repeat (20) @(negedge clk);
        rd_out(1'b0, w); check("R9 out level full", w, 32'd256);
        rd_out(1'b1, w); check("R2 out flags full", w, 32'h1);
        check("R6 ready held while stalled", 32'(loop_ready), 32'd1);
        rd_in(1'b0, w);  check("R10 in level max", w, 32'd256);
        rd_in(1'b1, w);  check("R2 in flags full", w, 32'h1);
        host_write(32'hDEAD_BEEF);
        repeat (4) @(negedge clk);
        rd_in(1'b0, w);  check("R3 write when full ignored", w, 32'd256);
    endtask

    // R9, R6: drain returns all accepted words in order.
    task automatic t_drain();
        logic [31:0] d, w; logic v;
        int bad_order = 0;
        for (int i = 0; i < 513; i++) begin
            for (int k = 0; k < 100; k++) begin
                rd_out(1'b1, w);
                if (w[1] == 1'b0) break;
                @(negedge clk);
            end
            host_read(d, v);
            if (!v || d !== pat(i)) begin
                bad_order++;
                check("R9 drained word in order", d, pat(i));
            end
        end
        check("R9 all words in order", 32'(bad_order), 32'd0);
        repeat (20) @(negedge clk);
        rd_out(1'b0, w); check("R3 excess word absent", w, 32'd0);
        rd_in(1'b1, w);  check("R2 in empty after drain", w, 32'h2);
        check("R7 ready low after drain", 32'(loop_ready), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_empty_read();
        t_latency();
        t_stall_fill();
        t_drain();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule